// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Ramp

This block scales a stereo stream of signed 24-bit PCM samples by a gain that moves gradually between full level and silence. When mute is requested, the gain walks down a raised-cosine curve. When mute is released, it walks back up along the same curve. Either way, the listener hears a fade instead of a click. The gain changes only on accepted samples, so the fade length is set in samples, not in clock cycles.

The gain has 33 levels, indexed 0 to 32. Index 0 is unity and index 32 is zero. The levels for indices 0 to 31 come from a built-in 32-entry table. The index moves by one level after every 32 accepted samples, so a complete fade takes 1024 samples.

A mode input picks where the mute request comes from: an external pin, or a bit driven from a control register. In register mode the block leaves reset fully muted. Audio is heard only after the register bit is cleared.

Top module: `cos_mute_ramp`

## Requirements
- R1: When reset is released with `regMode` low, the gain index is 0 (unity), `fullyMuted` is low, `outValid` is low and both sample outputs are zero.
- R2: When reset is released with `regMode` high, the gain index is 32 and `fullyMuted` is high. While `muteBit` stays high, every output sample is zero.
- R3: A sample pair accepted with `sampleValid` high at a clock edge appears on `leftOut`/`rightOut` at the next edge, with `outValid` high for one cycle. With no accepted sample, the outputs hold their value and `outValid` is low.
- R4: At gain index 0, each output equals its input bit for bit, including the values 0x7FFFFF and 0x800000.
- R5: The gain for index k (0..31) is round(32768·0.5·(1+cos(π·k/32))) as unsigned Q1.15. The gain for index 32 is 0. Each output is floor((x·g + 16384) / 32768), where x is the signed input sample and g is the gain.
- R6: While mute is requested and the index is below 32, the index rises by one after every 32 accepted samples. Starting from index 0, the first 32 samples use index 0, sample n uses index floor(n/32), and sample 1024 onward uses index 32.
- R7: While mute is not requested and the index is above 0, the index falls by one after every 32 accepted samples, until unity is reached.
- R8: When the request changes direction, the count within the current step restarts from zero. The index then moves one level at a time from its current value, with no jump in gain.
- R9: With `regMode` low, the request is `mutePin`, and `muteBit` has no effect.
- R10: With `regMode` high, the request is `muteBit`, and `mutePin` has no effect.
- R11: `fullyMuted` is high exactly when the gain index is 32. It reflects the index after the most recent accepted sample.
- R12: On cycles with `sampleValid` low, the gain index and the step count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | Qualifies a left/right sample pair |
| leftIn | input | 24 | Left input sample, signed |
| rightIn | input | 24 | Right input sample, signed |
| mutePin | input | 1 | Mute request from the external pin |
| muteBit | input | 1 | Mute request from the control register |
| regMode | input | 1 | 1 selects register control, 0 selects the pin |
| leftOut | output | 24 | Scaled left sample, signed |
| rightOut | output | 24 | Scaled right sample, signed |
| outValid | output | 1 | Marks a new output pair |
| fullyMuted | output | 1 | High while the gain is at the zero step |

## Verification
Full-scale positive and negative values, zero and minus one are sent at unity gain. These show whether the pass-through is truly bit-exact, or whether the rounding or sign extension is off by one LSB. A long pseudo-random stream is sent through a complete fade down and a complete fade up, and each sample is compared with a model built from the cosine curve. This separates a wrong table entry, a wrong step length and a wrong rounding rule, because each of these shows up at a different sample. A fade reversed part way through shows whether the step count restarts and whether the gain steps back without a jump. In register mode the pin is toggled while the bit holds mute. Idle gaps between samples show whether the ramp advances only on accepted samples.

// File: rtl/cos_mute_pkg.sv
package cos_mute_pkg;

  localparam int GAIN_W   = 16;
  localparam int FRAC_W   = 15;
  localparam int STEPS    = 32;
  localparam int IDX_W    = $clog2(STEPS + 1);
  localparam logic [GAIN_W-1:0] UNITY_GAIN = GAIN_W'(1 << FRAC_W);

  typedef struct packed {
    logic              sampleStb;
    logic [GAIN_W-1:0] gain;
  } ramp_strobe_t;

  // Q1.15 value of 0.5*(1+cos(pi*k/32)); index 32 and above is silence.
  function automatic logic [GAIN_W-1:0] cosGain(input logic [IDX_W-1:0] k);
    logic [GAIN_W-1:0] g;
    case (k)
      6'd0:  g = 16'd32768;
      6'd1:  g = 16'd32689;
      6'd2:  g = 16'd32453;
      6'd3:  g = 16'd32063;
      6'd4:  g = 16'd31521;
      6'd5:  g = 16'd30833;
      6'd6:  g = 16'd30007;
      6'd7:  g = 16'd29049;
      6'd8:  g = 16'd27969;
      6'd9:  g = 16'd26778;
      6'd10: g = 16'd25486;
      6'd11: g = 16'd24107;
      6'd12: g = 16'd22654;
      6'd13: g = 16'd21140;
      6'd14: g = 16'd19580;
      6'd15: g = 16'd17990;
      6'd16: g = 16'd16384;
      6'd17: g = 16'd14778;
      6'd18: g = 16'd13188;
      6'd19: g = 16'd11628;
      6'd20: g = 16'd10114;
      6'd21: g = 16'd8661;
      6'd22: g = 16'd7282;
      6'd23: g = 16'd5990;
      6'd24: g = 16'd4799;
      6'd25: g = 16'd3719;
      6'd26: g = 16'd2761;
      6'd27: g = 16'd1935;
      6'd28: g = 16'd1247;
      6'd29: g = 16'd705;
      6'd30: g = 16'd315;
      6'd31: g = 16'd79;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/cos_mute_ctrl.sv
module cos_mute_ctrl
  import cos_mute_pkg::*;
#(
  parameter int HOLD_SAMPLES = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         mutePin,
  input  logic         muteBit,
  input  logic         regMode,
  output ramp_strobe_t stb,
  output logic         fullyMuted
);

  localparam int CNT_W = (HOLD_SAMPLES > 1) ? $clog2(HOLD_SAMPLES) : 1;
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(STEPS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_SAMPLES - 1);

  logic [IDX_W-1:0] stepIdx;
  logic [CNT_W-1:0] holdCnt;
  logic             lastReq;

  logic             muteReq;
  logic             atTarget;
  logic             dirFlip;
  logic [CNT_W-1:0] baseCnt;
  logic             stepDone;

  always_comb begin
    muteReq  = regMode ? muteBit : mutePin;
    atTarget = muteReq ? (stepIdx == ZERO_IDX) : (stepIdx == '0);
    dirFlip  = (muteReq != lastReq);
    baseCnt  = dirFlip ? '0 : holdCnt;
    stepDone = (baseCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= regMode ? ZERO_IDX : '0;
      holdCnt <= '0;
      lastReq <= regMode;
    end else if (sampleValid) begin
      lastReq <= muteReq;
      if (atTarget) begin
        holdCnt <= '0;
      end else if (stepDone) begin
        holdCnt <= '0;
        stepIdx <= muteReq ? stepIdx + IDX_W'(1) : stepIdx - IDX_W'(1);
      end else begin
        holdCnt <= baseCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    stb.sampleStb = sampleValid;
    stb.gain      = cosGain(stepIdx);
    fullyMuted    = (stepIdx == ZERO_IDX);
  end

  // R12: no accepted sample, no movement of the ramp
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(stepIdx) && $stable(holdCnt));

  // R8: the index never moves by more than one level
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (stepIdx == $past(stepIdx)) ||
                    (stepIdx == $past(stepIdx) + IDX_W'(1)) ||
                    (stepIdx == $past(stepIdx) - IDX_W'(1)));

  // R11: a held mute request keeps the zero step
  a_r11_hold_muted: assert property (@(posedge clk) disable iff (!rstN)
    fullyMuted && sampleValid && muteReq |=> fullyMuted);

  // R6: the index stays inside its 33 levels
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= ZERO_IDX);

endmodule

// File: rtl/cos_mute_scale.sv
module cos_mute_scale
  import cos_mute_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     load,
  input  logic [GAIN_W-1:0]        gain,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);

  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (FRAC_W - 1);

  logic signed [GAIN_W:0]   gainS;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;

  always_comb begin
    gainS   = $signed({1'b0, gain});
    prod    = PROD_W'(din) * PROD_W'(gainS);
    rounded = prod + HALF_LSB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dout <= '0;
    end else if (load) begin
      dout <= rounded[FRAC_W +: DATA_W];
    end
  end

  // R4: unity gain passes the sample unchanged
  a_r4_unity_exact: assert property (@(posedge clk) disable iff (!rstN)
    load && (gain == UNITY_GAIN) |=> dout == $past(din));

  // R5: zero gain gives silence
  a_r5_zero_gain: assert property (@(posedge clk) disable iff (!rstN)
    load && (gain == '0) |=> dout == '0);

  // R3: output holds without a new sample
  a_r3_hold_out: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(dout));

endmodule

// File: rtl/cos_mute_datapath.sv
module cos_mute_datapath
  import cos_mute_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CHANNELS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ramp_strobe_t             stb,
  input  logic signed [DATA_W-1:0] chanIn  [CHANNELS],
  output logic signed [DATA_W-1:0] chanOut [CHANNELS],
  output logic                     outValid
);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    cos_mute_scale #(
      .DATA_W(DATA_W)
    ) scale_i (
      .clk (clk),
      .rstN(rstN),
      .load(stb.sampleStb),
      .gain(stb.gain),
      .din (chanIn[c]),
      .dout(chanOut[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= stb.sampleStb;
    end
  end

  // R3: one output pulse per accepted sample
  a_r3_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleStb |=> outValid);

endmodule

// File: rtl/cos_mute_ramp.sv
module cos_mute_ramp
  import cos_mute_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int HOLD_SAMPLES = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] leftIn,
  input  logic signed [DATA_W-1:0] rightIn,
  input  logic                     mutePin,
  input  logic                     muteBit,
  input  logic                     regMode,
  output logic signed [DATA_W-1:0] leftOut,
  output logic signed [DATA_W-1:0] rightOut,
  output logic                     outValid,
  output logic                     fullyMuted
);

  ramp_strobe_t            stb;
  logic signed [DATA_W-1:0] chanIn  [2];
  logic signed [DATA_W-1:0] chanOut [2];

  assign chanIn[0] = leftIn;
  assign chanIn[1] = rightIn;
  assign leftOut   = chanOut[0];
  assign rightOut  = chanOut[1];

  cos_mute_ctrl #(
    .HOLD_SAMPLES(HOLD_SAMPLES)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .mutePin    (mutePin),
    .muteBit    (muteBit),
    .regMode    (regMode),
    .stb        (stb),
    .fullyMuted (fullyMuted)
  );

  cos_mute_datapath #(
    .DATA_W  (DATA_W),
    .CHANNELS(2)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .chanIn  (chanIn),
    .chanOut (chanOut),
    .outValid(outValid)
  );

  // R2: register mode with the bit set keeps the outputs silent
  a_r2_reg_silent: assert property (@(posedge clk) disable iff (!rstN)
    regMode && muteBit && fullyMuted && sampleValid |=>
      (leftOut == '0) && (rightOut == '0));

endmodule

// File: tb/cos_mute_ramp_tb_top.sv
module cos_mute_ramp_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [23:0] leftIn = '0;
  logic signed [23:0] rightIn = '0;
  logic mutePin = 1'b0;
  logic muteBit = 1'b0;
  logic regMode = 1'b0;
  logic signed [23:0] leftOut;
  logic signed [23:0] rightOut;
  logic outValid;
  logic fullyMuted;

  always #4 clk = ~clk;

  cos_mute_ramp dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .leftIn(leftIn), .rightIn(rightIn),
    .mutePin(mutePin), .muteBit(muteBit), .regMode(regMode),
    .leftOut(leftOut), .rightOut(rightOut),
    .outValid(outValid), .fullyMuted(fullyMuted)
  );

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  // reference model of the ramp
  int mIdx = 0;
  int mCnt = 0;
  bit mDir = 1'b0;
  logic signed [23:0] lastL = '0;
  logic signed [23:0] lastR = '0;

  logic signed [23:0] qL[$];
  logic signed [23:0] qR[$];
  string qTag[$];

  task automatic checkVal(input string req, input string what,
                          input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int refGain(input int k);
    real v;
    if (k >= 32) return 0;
    v = 16384.0 * (1.0 + $cos(3.14159265358979 * k / 32.0));
    return $rtoi(v + 0.5);
  endfunction

  function automatic logic signed [23:0] refScale(input logic signed [23:0] x,
                                                  input int g);
    longint p;
    p = longint'(x) * longint'(g);
    p = (p + 64'sd16384) >>> 15;
    return 24'(p);
  endfunction

  task automatic modelReset();
    mIdx = regMode ? 32 : 0;
    mCnt = 0;
    mDir = regMode;
    lastL = '0;
    lastR = '0;
  endtask

  // driver: called at a falling edge, returns at the following falling edge
  task automatic sendSample(input logic signed [23:0] l,
                            input logic signed [23:0] r,
                            input string tag);
    bit req;
    int g;
    int base;
    bit atTgt;
    req = regMode ? muteBit : mutePin;
    g = refGain(mIdx);
    lastL = refScale(l, g);
    lastR = refScale(r, g);
    qL.push_back(lastL);
    qR.push_back(lastR);
    qTag.push_back(tag);
    leftIn = l;
    rightIn = r;
    sampleValid = 1'b1;
    base = (req != mDir) ? 0 : mCnt;
    atTgt = req ? (mIdx == 32) : (mIdx == 0);
    if (atTgt) mCnt = 0;
    else if (base == 31) begin
      mCnt = 0;
      mIdx = req ? mIdx + 1 : mIdx - 1;
    end else mCnt = base + 1;
    mDir = req;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    checkVal("R11", "fullyMuted", longint'(fullyMuted), longint'(mIdx == 32));
  endtask

  task automatic sendRandom(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sendSample(lfsr[23:0], ~lfsr[31:8], tag);
    end
  endtask

  task automatic sendEdges(input string tag);
    sendSample(24'sh7FFFFF, 24'sh800000, tag);
    sendSample(24'sh800000, 24'sh7FFFFF, tag);
    sendSample(24'sh000000, 24'shFFFFFF, tag);
    sendSample(24'sh000001, 24'sh400001, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkVal("R3", "leftOut hold", longint'(leftOut), longint'(lastL));
      checkVal("R3", "outValid idle", longint'(outValid), 0);
      checkVal("R12", "fullyMuted idle", longint'(fullyMuted), longint'(mIdx == 32));
    end
  endtask

  task automatic doReset(input bit mode);
    @(negedge clk);
    sampleValid = 1'b0;
    regMode = mode;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    if (mode) begin
      checkVal("R2", "fullyMuted after reset", longint'(fullyMuted), 1);
    end else begin
      checkVal("R1", "fullyMuted after reset", longint'(fullyMuted), 0);
      checkVal("R1", "outValid after reset", longint'(outValid), 0);
      checkVal("R1", "leftOut after reset", longint'(leftOut), 0);
      checkVal("R1", "rightOut after reset", longint'(rightOut), 0);
    end
  endtask

  // monitor: compares every output pair with the scoreboard
  always @(negedge clk) begin
    if (outValid) begin
      if (qL.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R3 unexpected outValid: actual 1 expected 0");
      end else begin
        logic signed [23:0] eL;
        logic signed [23:0] eR;
        string t;
        eL = qL.pop_front();
        eR = qR.pop_front();
        t = qTag.pop_front();
        checkVal(t, "leftOut", longint'(leftOut), longint'(eL));
        checkVal(t, "rightOut", longint'(rightOut), longint'(eR));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // pin mode, unity pass-through, register bit set but ignored (R9)
    muteBit = 1'b1;
    mutePin = 1'b0;
    doReset(1'b0);
    sendEdges("R4");
    sendRandom(40, "R9");
    idle(3);

    // full fade down with idle gaps
    mutePin = 1'b1;
    for (int blk = 0; blk < 11; blk++) begin
      sendRandom(100, (blk < 5) ? "R5" : "R6");
      idle(2);
    end
    sendEdges("R6");

    // partial fade up, reversal, then full fade up
    mutePin = 1'b0;
    sendRandom(500, "R7");
    mutePin = 1'b1;
    sendRandom(70, "R8");
    mutePin = 1'b0;
    sendRandom(1100, "R7");
    sendEdges("R4");
    idle(2);

    // register mode: starts muted, pin ignored
    muteBit = 1'b1;
    doReset(1'b1);
    for (int i = 0; i < 40; i++) begin
      mutePin = i[0];
      sendRandom(1, "R2");
    end
    muteBit = 1'b0;
    mutePin = 1'b1;
    sendRandom(600, "R10");
    mutePin = 1'b0;
    sendRandom(500, "R10");
    sendEdges("R10");
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule